// File: doc/BRIEF.md
# Measurement Subsystem Power-Up Sequencer

This block is a small state machine that brings a measurement subsystem up and down on single-cycle trigger pulses. It shows its present condition on a 2-bit state field. A power-up request turns on the reference first and waits out a selectable settling delay. It then turns on subsystem power and waits a bounded number of cycles for a PLL lock indication. If lock arrives within that window, the block becomes ready. If it does not, the block drops back to off and raises a sticky timeout flag, which can be routed to an interrupt.

A standby condition keeps only the reference powered, so a later power-up skips the settling delay. The crystal oscillator is outside this block's control and must already be running and stable before any power-up is requested. Control inputs and status outputs are plain ports; the register interface sits elsewhere.

Top module: `pwr_seq_top`

## Requirements
- R1: `state_o` encodes the condition as 0 = off, 1 = standby, 2 = in transition, 3 = ready; after a power-up trigger from off it reads 2.
- R2: After a power-up trigger from off, `ref_en` is 1 and `sub_pwr_en` is 0 for exactly (`holdoff_sel`+1)×HOLD_UNIT cycles; then `sub_pwr_en` rises.
- R3: If `pll_lock` is sampled high on any of the LOCK_WIN lock-wait cycles, including the last one, the state becomes ready (3) on the next cycle with both enables on.
- R4: If `pll_lock` stays low for all LOCK_WIN lock-wait cycles, the state returns to off (0) with both enables low and `tmo_flag` set to 1.
- R5: While the state reads 2, `trig_up`, `trig_down` and `trig_stby` have no effect on the sequence or its timing.
- R6: `tmo_flag` remains 1 until a cycle with `tmo_clr` high clears it.
- R7: `irq` equals `tmo_flag` AND `tmo_ie`.
- R8: `trig_down` in ready or standby moves to off in one cycle with `ref_en` and `sub_pwr_en` both 0. `trig_down` takes priority over any other trigger.
- R9: `trig_stby` in ready moves to standby (1) in one cycle with `ref_en` = 1 and `sub_pwr_en` = 0.
- R10: `trig_up` in standby moves straight to the lock wait: the next cycle reads state 2 with `sub_pwr_en` = 1.
- R11: A low `rst_n` sampled at a clock edge forces off, clears both enables and clears `tmo_flag`.
- R12: Triggers with no defined move are ignored: `trig_down` and `trig_stby` in off, `trig_up` in ready, and `trig_stby` in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_up | input | 1 | Power-up request pulse |
| trig_down | input | 1 | Power-down request pulse |
| trig_stby | input | 1 | Standby request pulse |
| holdoff_sel | input | 4 | Settling-delay select; delay = (value+1)×HOLD_UNIT cycles |
| pll_lock | input | 1 | PLL lock indication |
| tmo_clr | input | 1 | Write-one-to-clear strobe for the timeout flag |
| tmo_ie | input | 1 | Timeout interrupt enable |
| state_o | output | 2 | Current condition code |
| ref_en | output | 1 | Reference enable |
| sub_pwr_en | output | 1 | Subsystem power enable |
| tmo_flag | output | 1 | Sticky lock-timeout flag |
| irq | output | 1 | Enabled timeout interrupt |

## Verification
The hardest case to reach is lock arriving on the very last lock-wait cycle. On that cycle the counter's expiry and the lock input compete at the same edge. A second hard case is a trigger landing on the cycle where the hold-off ends. The bench runs with a small hold-off unit and a small lock window, so every hold-off setting can be swept. For each setting it measures the phase lengths by counting cycles at the ports. It also steps the lock arrival through every lock-wait index, including the final one. Ignored triggers are injected in the middle of the hold-off, and the measured length must still match the arithmetic.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  // externally visible condition code
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_STBY  = 2'd1,
    ST_TRANS = 2'd2,
    ST_READY = 2'd3
  } pwr_status_t;

  // internal sequencing phase
  typedef enum logic [2:0] {
    PH_OFF,
    PH_HOLD,
    PH_LOCK,
    PH_READY,
    PH_STBY
  } pwr_phase_t;

  function automatic pwr_status_t status_of(pwr_phase_t ph);
    case (ph)
      PH_HOLD, PH_LOCK: return ST_TRANS;
      PH_READY:         return ST_READY;
      PH_STBY:          return ST_STBY;
      default:          return ST_OFF;
    endcase
  endfunction

  // number of settling cycles for a given select value
  function automatic int unsigned holdoff_cycles(logic [3:0] sel, int unsigned unit);
    return (int'(sel) + 1) * unit;
  endfunction

endpackage

// File: rtl/pwr_seq_cnt.sv
module pwr_seq_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)      cnt <= '0;
    else if (en && !done)   cnt <= cnt + 1'b1;
  end

  assign done = (cnt == limit);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !done) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pwr_seq_irq.sv
module pwr_seq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo_event,
  input  logic tmo_clr,
  input  logic tmo_ie,
  output logic tmo_flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)         tmo_flag <= 1'b0;
    else if (tmo_event) tmo_flag <= 1'b1;
    else if (tmo_clr)   tmo_flag <= 1'b0;
  end

  assign irq = tmo_flag & tmo_ie;

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !tmo_clr) |=> tmo_flag);
  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_event |=> tmo_flag);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig_up,
  input  logic        trig_down,
  input  logic        trig_stby,
  input  logic        pll_lock,
  input  logic        cnt_done,
  output pwr_phase_t  phase,
  output logic        cnt_clr,
  output logic        cnt_en,
  output logic        tmo_event,
  output logic [1:0]  state_o,
  output logic        ref_en,
  output logic        sub_pwr_en
);
  pwr_phase_t nxt;

  always_comb begin
    nxt       = phase;
    tmo_event = 1'b0;
    case (phase)
      PH_OFF:   if (trig_up) nxt = PH_HOLD;
      PH_HOLD:  if (cnt_done) nxt = PH_LOCK;
      PH_LOCK: begin
        if (pll_lock) nxt = PH_READY;
        else if (cnt_done) begin
          nxt       = PH_OFF;
          tmo_event = 1'b1;
        end
      end
      PH_READY: begin
        if (trig_down)      nxt = PH_OFF;
        else if (trig_stby) nxt = PH_STBY;
      end
      PH_STBY: begin
        if (trig_down)    nxt = PH_OFF;
        else if (trig_up) nxt = PH_LOCK;
      end
      default: nxt = PH_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_OFF;
    else        phase <= nxt;
  end

  assign cnt_clr    = (nxt != phase);
  assign cnt_en     = (phase == PH_HOLD) || (phase == PH_LOCK);
  assign state_o    = status_of(phase);
  assign ref_en     = (phase != PH_OFF);
  assign sub_pwr_en = (phase == PH_LOCK) || (phase == PH_READY);

  // R5
  trans_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_TRANS) |=> (state_o != ST_STBY));
  // R4
  timeout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOCK && cnt_done && !pll_lock) |=> (state_o == ST_OFF && !ref_en));
  // R8
  down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == ST_READY || state_o == ST_STBY) && trig_down) |=>
      (state_o == ST_OFF && !ref_en && !sub_pwr_en));
  // R9
  stby_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_STBY) |-> (ref_en && !sub_pwr_en));
  // R10
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_STBY && trig_up && !trig_down) |=> (sub_pwr_en && state_o == ST_TRANS));
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int HOLD_UNIT = 4688,
  parameter int LOCK_WIN  = 40000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_up,
  input  logic       trig_down,
  input  logic       trig_stby,
  input  logic [3:0] holdoff_sel,
  input  logic       pll_lock,
  input  logic       tmo_clr,
  input  logic       tmo_ie,
  output logic [1:0] state_o,
  output logic       ref_en,
  output logic       sub_pwr_en,
  output logic       tmo_flag,
  output logic       irq
);
  localparam int HOLD_MAX = HOLD_UNIT * 16;
  localparam int CNT_MAX  = (HOLD_MAX > LOCK_WIN) ? HOLD_MAX : LOCK_WIN;
  localparam int CW       = $clog2(CNT_MAX + 1);

  pwr_phase_t    phase;
  logic          cnt_clr, cnt_en, cnt_done, tmo_event;
  logic [CW-1:0] limit;

  always_comb begin
    if (phase == PH_HOLD) limit = CW'(holdoff_cycles(holdoff_sel, HOLD_UNIT) - 1);
    else                  limit = CW'(LOCK_WIN - 1);
  end

  pwr_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .trig_up(trig_up), .trig_down(trig_down), .trig_stby(trig_stby),
    .pll_lock(pll_lock), .cnt_done(cnt_done),
    .phase(phase), .cnt_clr(cnt_clr), .cnt_en(cnt_en), .tmo_event(tmo_event),
    .state_o(state_o), .ref_en(ref_en), .sub_pwr_en(sub_pwr_en)
  );

  pwr_seq_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
    .limit(limit), .done(cnt_done)
  );

  pwr_seq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .tmo_event(tmo_event), .tmo_clr(tmo_clr),
    .tmo_ie(tmo_ie), .tmo_flag(tmo_flag), .irq(irq)
  );

  // R11
  reset_chk: assert property (@(posedge clk)
    !rst_n |=> (state_o == 2'd0 && !ref_en && !sub_pwr_en && !tmo_flag));
endmodule

// File: tb/tb_pwr_seq_top.sv
module tb_pwr_seq_top;
  localparam int HU = 2;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_up = 0, trig_down = 0, trig_stby = 0, pll_lock = 0, tmo_clr = 0, tmo_ie = 0;
  logic [3:0] holdoff_sel = 4'd0;
  logic [1:0] state_o;
  logic ref_en, sub_pwr_en, tmo_flag, irq;
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwr_seq_top #(.HOLD_UNIT(HU), .LOCK_WIN(LW)) dut (
    .clk(clk), .rst_n(rst_n), .trig_up(trig_up), .trig_down(trig_down),
    .trig_stby(trig_stby), .holdoff_sel(holdoff_sel), .pll_lock(pll_lock),
    .tmo_clr(tmo_clr), .tmo_ie(tmo_ie), .state_o(state_o), .ref_en(ref_en),
    .sub_pwr_en(sub_pwr_en), .tmo_flag(tmo_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  function automatic int pack_rails(input logic [1:0] s, input logic r, input logic p);
    return {28'd0, s, r, p};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=0", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    tick; tick;
    chk(state_o == 2'd0 && !ref_en && !sub_pwr_en && !tmo_flag && !irq, "R11 reset state",
        pack_rails(state_o, ref_en, sub_pwr_en), 0);
    rst_n = 1'b1;
    tick;

    for (int sel = 0; sel < 16; sel++) begin
      holdoff_sel = 4'(sel);
      tmo_ie = sel[1];
      // R12: down/standby in off ignored
      trig_down = 1; trig_stby = 1; tick; trig_down = 0; trig_stby = 0;
      chk(state_o == 2'd0 && !ref_en, "R12 off ignores down/stby", state_o, 0);
      // power-up from off
      trig_up = 1; tick; trig_up = 0;
      chk(state_o == 2'd2, "R1 transition code", state_o, 2);
      n = 0;
      while (state_o == 2'd2 && !sub_pwr_en && n < 1000) begin
        n++;
        if (n == 2) begin
          trig_down = sel[0]; trig_stby = !sel[0]; trig_up = 1;
        end else begin
          trig_down = 0; trig_stby = 0; trig_up = 0;
        end
        tick;
      end
      trig_down = 0; trig_stby = 0; trig_up = 0;
      // R2, R5: hold-off length unaffected by injected triggers
      chk(n == (sel + 1) * HU, "R2/R5 hold-off length", n, (sel + 1) * HU);
      chk(state_o == 2'd2 && ref_en && sub_pwr_en, "R2 power on after hold-off",
          pack_rails(state_o, ref_en, sub_pwr_en), 11);
      if (sel[0]) begin
        n = 0;
        while (state_o == 2'd2 && n < 1000) begin n++; tick; end
        chk(n == LW, "R4 lock window length", n, LW);
        chk(state_o == 2'd0 && !ref_en && !sub_pwr_en && tmo_flag, "R4 timeout to off",
            pack_rails(state_o, ref_en, sub_pwr_en) * 2 + int'(tmo_flag), 1);
        chk(irq == tmo_ie, "R7 irq follows enable", irq, tmo_ie);
        tick; tick; tick;
        chk(tmo_flag == 1'b1, "R6 flag sticky", tmo_flag, 1);
        tmo_ie = !tmo_ie; #0;
        tick;
        chk(irq == tmo_ie, "R7 irq with other enable", irq, tmo_ie);
        tmo_clr = 1; tick; tmo_clr = 0;
        chk(tmo_flag == 1'b0 && irq == 1'b0, "R6 flag cleared", tmo_flag, 0);
      end else begin
        int d = (sel / 2) % LW;
        n = 0;
        while (state_o == 2'd2 && n < 1000) begin
          if (n == d) pll_lock = 1;
          n++;
          tick;
        end
        chk(n == d + 1, "R3 lock cycles", n, d + 1);
        chk(state_o == 2'd3 && ref_en && sub_pwr_en && !tmo_flag, "R3 ready",
            pack_rails(state_o, ref_en, sub_pwr_en), 15);
        trig_up = 1; tick; trig_up = 0;
        chk(state_o == 2'd3, "R12 up ignored in ready", state_o, 3);
        trig_stby = 1; tick; trig_stby = 0;
        chk(state_o == 2'd1 && ref_en && !sub_pwr_en, "R9 standby rails",
            pack_rails(state_o, ref_en, sub_pwr_en), 6);
        pll_lock = 0;
        trig_stby = 1; tick; trig_stby = 0;
        chk(state_o == 2'd1, "R12 stby ignored in standby", state_o, 1);
        trig_up = 1; tick; trig_up = 0;
        chk(state_o == 2'd2 && sub_pwr_en && ref_en, "R10 wake skips hold-off",
            pack_rails(state_o, ref_en, sub_pwr_en), 11);
        pll_lock = 1; tick;
        chk(state_o == 2'd3, "R3 ready after wake", state_o, 3);
        if (sel % 4 == 2) begin
          trig_stby = 1; tick; trig_stby = 0;
        end
        trig_down = 1; trig_stby = 1; trig_up = 1; tick;
        trig_down = 0; trig_stby = 0; trig_up = 0;
        pll_lock = 0;
        chk(state_o == 2'd0 && !ref_en && !sub_pwr_en, "R8 power-down",
            pack_rails(state_o, ref_en, sub_pwr_en), 0);
      end
    end

    // R11: reset during hold-off with flag set
    holdoff_sel = 4'd3;
    trig_up = 1; tick; trig_up = 0;
    while (state_o == 2'd2 && n < 2000) begin n++; tick; end
    chk(tmo_flag == 1'b1, "R4 flag before reset", tmo_flag, 1);
    trig_up = 1; tick; trig_up = 0;
    tick;
    rst_n = 0; tick; rst_n = 1;
    chk(state_o == 2'd0 && !ref_en && !sub_pwr_en && !tmo_flag, "R11 reset mid-sequence",
        pack_rails(state_o, ref_en, sub_pwr_en) * 2 + int'(tmo_flag), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule